// File: doc/BRIEF.md
# Interrupt Status and Clear Controller

This block keeps the interrupt state of a serial bus controller. Ten edge-type sources are pulsed by the datapath and latched as sticky flags. Two level-type sources follow the receive-full and transmit-empty threshold signals. A software-visible mask selects which flags may raise the single interrupt line, and the masked view can be read back.

Each sticky flag is cleared by a read of its own clear address. A read of the combined clear address clears all ten at once. A cause vector is captured together with the transmit-abort flag. It is cleared by the same read that clears that flag, so software must read the cause first.

The register port is a plain read/write strobe interface. Read data is registered and is valid in the cycle after the strobe. The reset is synchronous and active high.

Top module: `irq_status_ctrl`

## Requirements
- R1: The raw status (offset 0x34) has this bit order: 0 rx_under, 1 rx_over, 2 rx_full, 3 tx_over, 4 tx_empty, 5 rd_req, 6 tx_abrt, 7 rx_done, 8 activity, 9 stop_det, 10 start_det, 11 gen_call. Event input `src_evt_i[k]` lists the ten edge sources in ascending bit order (k=0..9 maps to bits 0,1,3,5,6,7,8,9,10,11). A pulse sets its flag at the next clock edge, and the flag stays set.
- R2: Bits 2 and 4 of the raw status are registered copies of `rx_lvl_i` and `tx_lvl_i`. No clear address affects them.
- R3: The mask register (offset 0x30, bits 11:0, reset 0) is written through the register port. The masked status (offset 0x2C) reads as raw AND mask.
- R4: `irq_o` is a register that equals the OR of the masked status bits one cycle earlier.
- R5: A read of an individual clear address clears only its own flag. The addresses run from 0x44 in steps of 4, in the order rx_under, rx_over, tx_over, rd_req, tx_abrt, rx_done, activity, stop_det, start_det, gen_call. The read returns that flag's value before the clear, in bit 0.
- R6: A read of the combined clear address 0x40 clears all ten edge flags. It returns, in bit 0, whether any edge flag was set before the clear.
- R7: An event that arrives in the same cycle as a clear read of its flag leaves the flag set.
- R8: The abort cause register (offset 0x80) ORs in `abort_cause_i` whenever the tx_abrt event pulses. A read of 0x54 or 0x40 clears it. A cause arriving in the same cycle as the clear is kept.
- R9: Read data is registered and appears the cycle after the read strobe. Unmapped addresses and idle cycles return 0. Reads of 0x2C, 0x30, 0x34 and 0x80, and writes to any address other than 0x30, change no state.
- R10: Synchronous reset clears the flags, the mask, the cause register, `irq_o` and the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address of the access |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| src_evt_i | input | 10 | Edge-source event pulses, in ascending bit order |
| rx_lvl_i | input | 1 | Receive threshold level (raw bit 2) |
| tx_lvl_i | input | 1 | Transmit threshold level (raw bit 4) |
| abort_cause_i | input | CAUSE_W | Cause vector, sampled with the tx_abrt event |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions check the following on every cycle:
- an event always leaves its flag set one cycle later, even when a clear read coincides;
- an isolated individual or combined clear empties the flags it targets;
- the level bits track their inputs with one cycle of delay;
- `irq_o` follows the masked status one cycle later;
- a clear of the cause register without a coinciding abort empties it.

Only the bench scenarios can show the following:
- the exact bit and address positions;
- that a clear leaves the other flags untouched;
- the pre-clear values returned by clear reads;
- accumulation in the cause register;
- that unmapped reads and stray writes have no effect.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
  localparam int NUM_SRC  = 12;
  localparam int NUM_EDGE = 10;

  localparam int BIT_RX_FULL   = 2;
  localparam int BIT_TX_EMPTY  = 4;
  localparam int EDGE_TX_ABORT = 4;   // edge index of tx_abrt (raw bit 6)

  localparam int OFF_MSTAT    = 'h2C;
  localparam int OFF_MASK     = 'h30;
  localparam int OFF_RAW      = 'h34;
  localparam int OFF_CLR_ALL  = 'h40;
  localparam int OFF_CLR_BASE = 'h44;
  localparam int OFF_CAUSE    = 'h80;

  // raw bits that are sticky edge flags (bits 2 and 4 are levels)
  localparam logic [NUM_SRC-1:0] EDGE_MASK = 12'hFEB;

  // edge index -> raw status bit position
  function automatic int edge_bit(input int k);
    if (k < 2)       return k;
    else if (k == 2) return 3;
    else             return k + 2;
  endfunction

  // edge index -> individual clear address
  function automatic int clr_off(input int k);
    return OFF_CLR_BASE + 4 * k;
  endfunction
endpackage

// File: rtl/irqs_addr_decode.sv
module irqs_addr_decode
  import irqs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_EDGE-1:0] ind_hit_o,   // individual clear read hit
  output logic [NUM_EDGE-1:0] clr_edge_o,  // effective clear per edge flag
  output logic              clr_all_o,
  output logic              sel_mstat_o,
  output logic              sel_mask_o,
  output logic              sel_raw_o,
  output logic              sel_cause_o,
  output logic              wr_mask_o,
  output logic              clr_cause_o
);
  assign clr_all_o   = rd_i && (addr_i == ADDR_W'(OFF_CLR_ALL));
  assign sel_mstat_o = rd_i && (addr_i == ADDR_W'(OFF_MSTAT));
  assign sel_mask_o  = rd_i && (addr_i == ADDR_W'(OFF_MASK));
  assign sel_raw_o   = rd_i && (addr_i == ADDR_W'(OFF_RAW));
  assign sel_cause_o = rd_i && (addr_i == ADDR_W'(OFF_CAUSE));
  assign wr_mask_o   = wr_i && (addr_i == ADDR_W'(OFF_MASK));

  for (genvar k = 0; k < NUM_EDGE; k++) begin : g_clr
    assign ind_hit_o[k]  = rd_i && (addr_i == ADDR_W'(clr_off(k)));
    assign clr_edge_o[k] = ind_hit_o[k] || clr_all_o;
  end

  assign clr_cause_o = clr_edge_o[EDGE_TX_ABORT];
endmodule

// File: rtl/irqs_flag_bank.sv
module irqs_flag_bank
  import irqs_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_EDGE-1:0] evt_i,
  input  logic [NUM_EDGE-1:0] clr_i,
  input  logic                rx_lvl_i,
  input  logic                tx_lvl_i,
  output logic [NUM_SRC-1:0]  raw_o
);
  logic [NUM_EDGE-1:0] flag_q;
  logic                rx_lvl_q, tx_lvl_q;

  for (genvar k = 0; k < NUM_EDGE; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flag_q[k] <= 1'b0;
      else     flag_q[k] <= (flag_q[k] & ~clr_i[k]) | evt_i[k];  // set wins
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_lvl_q <= 1'b0;
      tx_lvl_q <= 1'b0;
    end else begin
      rx_lvl_q <= rx_lvl_i;
      tx_lvl_q <= tx_lvl_i;
    end
  end

  always_comb begin
    raw_o = '0;
    for (int k = 0; k < NUM_EDGE; k++) raw_o[edge_bit(k)] = flag_q[k];
    raw_o[BIT_RX_FULL]  = rx_lvl_q;
    raw_o[BIT_TX_EMPTY] = tx_lvl_q;
  end
endmodule

// File: rtl/irqs_cause_reg.sv
module irqs_cause_reg #(
  parameter int CAUSE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic               clear_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic [CAUSE_W-1:0] cause_o
);
  always_ff @(posedge clk) begin
    if (rst) cause_o <= '0;
    else     cause_o <= (clear_i ? '0 : cause_o) | (load_i ? cause_i : '0);
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irqs_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_rd_i,
  input  logic                reg_wr_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic [NUM_EDGE-1:0] src_evt_i,
  input  logic                rx_lvl_i,
  input  logic                tx_lvl_i,
  input  logic [CAUSE_W-1:0]  abort_cause_i,
  output logic                irq_o
);
  logic [NUM_EDGE-1:0] ind_hit, clr_edge;
  logic clr_all, sel_mstat, sel_mask, sel_raw, sel_cause, wr_mask, clr_cause;
  logic [NUM_SRC-1:0]  raw_q, mask_q;
  logic [CAUSE_W-1:0]  cause_q;
  logic [DATA_W-1:0]   rd_next;
  logic                wdata_unused;

  assign wdata_unused = ^reg_wdata_i[DATA_W-1:NUM_SRC];

  irqs_addr_decode #(.ADDR_W(ADDR_W)) dec_i (
    .rd_i(reg_rd_i), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .ind_hit_o(ind_hit), .clr_edge_o(clr_edge), .clr_all_o(clr_all),
    .sel_mstat_o(sel_mstat), .sel_mask_o(sel_mask), .sel_raw_o(sel_raw),
    .sel_cause_o(sel_cause), .wr_mask_o(wr_mask), .clr_cause_o(clr_cause)
  );

  irqs_flag_bank bank_i (
    .clk(clk), .rst(rst), .evt_i(src_evt_i), .clr_i(clr_edge),
    .rx_lvl_i(rx_lvl_i), .tx_lvl_i(tx_lvl_i), .raw_o(raw_q)
  );

  irqs_cause_reg #(.CAUSE_W(CAUSE_W)) cause_i (
    .clk(clk), .rst(rst), .load_i(src_evt_i[EDGE_TX_ABORT]),
    .clear_i(clr_cause), .cause_i(abort_cause_i), .cause_o(cause_q)
  );

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata_i[NUM_SRC-1:0];
  end

  always_comb begin
    rd_next = '0;
    if (sel_mstat) rd_next = DATA_W'(raw_q & mask_q);
    if (sel_mask)  rd_next = DATA_W'(mask_q);
    if (sel_raw)   rd_next = DATA_W'(raw_q);
    if (sel_cause) rd_next = DATA_W'(cause_q);
    if (clr_all)   rd_next = DATA_W'(|(raw_q & EDGE_MASK));
    for (int k = 0; k < NUM_EDGE; k++)
      if (ind_hit[k]) rd_next = DATA_W'(raw_q[edge_bit(k)]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_o <= '0;
      irq_o       <= 1'b0;
    end else begin
      reg_rdata_o <= rd_next;
      irq_o       <= |(raw_q & mask_q);
    end
  end
endmodule

// File: rtl/irqs_checker.sv
module irqs_checker
  import irqs_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CAUSE_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                reg_rd_i,
  input logic [ADDR_W-1:0]   reg_addr_i,
  input logic [NUM_EDGE-1:0] src_evt_i,
  input logic                rx_lvl_i,
  input logic                tx_lvl_i,
  input logic [NUM_SRC-1:0]  raw_q,
  input logic [NUM_SRC-1:0]  mask_q,
  input logic [CAUSE_W-1:0]  cause_q,
  input logic                irq_o
);
  for (genvar k = 0; k < NUM_EDGE; k++) begin : g_chk
    // event sets its flag, even against a clear (R1, R7)
    assert_evt_sets_R7: assert property (@(posedge clk) disable iff (rst)
      src_evt_i[k] |=> raw_q[edge_bit(k)]);
    // isolated individual clear empties the flag
    assert_ind_clear_R5: assert property (@(posedge clk) disable iff (rst)
      (reg_rd_i && reg_addr_i == ADDR_W'(clr_off(k)) && !src_evt_i[k])
      |=> !raw_q[edge_bit(k)]);
  end

  assert_all_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_i && reg_addr_i == ADDR_W'(OFF_CLR_ALL) && src_evt_i == '0)
    |=> ((raw_q & EDGE_MASK) == '0));

  assert_level_rx_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> raw_q[BIT_RX_FULL] == $past(rx_lvl_i));

  assert_level_tx_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> raw_q[BIT_TX_EMPTY] == $past(tx_lvl_i));

  assert_irq_follow_R4: assert property (@(posedge clk) disable iff (rst)
    !rst |=> irq_o == $past(|(raw_q & mask_q)));

  assert_cause_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_i && (reg_addr_i == ADDR_W'(clr_off(EDGE_TX_ABORT)) ||
                  reg_addr_i == ADDR_W'(OFF_CLR_ALL)) && !src_evt_i[EDGE_TX_ABORT])
    |=> cause_q == '0);

  assert_raw_read_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_i && reg_addr_i == ADDR_W'(OFF_RAW) && src_evt_i == '0)
    |=> ((raw_q & EDGE_MASK) == ($past(raw_q) & EDGE_MASK)));
endmodule

bind irq_status_ctrl irqs_checker #(.ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W)) chk_i (
  .clk(clk), .rst(rst), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
  .src_evt_i(src_evt_i), .rx_lvl_i(rx_lvl_i), .tx_lvl_i(tx_lvl_i),
  .raw_q(raw_q), .mask_q(mask_q), .cause_q(cause_q), .irq_o(irq_o)
);

// File: tb/irq_status_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_status_ctrl_tb_top;
  localparam int AW = 8, DW = 32, CW = 16;

  logic clk = 0, rst = 1;
  logic rd = 0, wr = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic [9:0] evt = '0;
  logic rxl = 0, txl = 0;
  logic [CW-1:0] cause = '0;
  logic irq;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [DW-1:0] last_rd;
  int ebit[10] = '{0, 1, 3, 5, 6, 7, 8, 9, 10, 11};
  logic [11:0] exp_raw;

  always #2.5 clk = ~clk;

  irq_status_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CAUSE_W(CW)) dut_i (
    .clk(clk), .rst(rst), .reg_rd_i(rd), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .src_evt_i(evt),
    .rx_lvl_i(rxl), .tx_lvl_i(txl), .abort_cause_i(cause), .irq_o(irq));

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  // one cycle: drive at negedge, capture at posedge, sample at next negedge
  task automatic cyc(input logic r, input logic w, input int a, input logic [DW-1:0] d,
                     input logic [9:0] e, input logic [CW-1:0] c);
    rd = r; wr = w; addr = AW'(a); wdata = d; evt = e; cause = c;
    @(posedge clk); @(negedge clk);
    rd = 0; wr = 0; evt = '0; cause = '0; addr = '0;
    last_rd = rdata;
  endtask

  task automatic rdr(input int a);
    cyc(1, 0, a, '0, '0, '0);
  endtask

  task automatic wrr(input int a, input logic [DW-1:0] d);
    cyc(0, 1, a, d, '0, '0);
  endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 0;
    // R10 reset state
    chk("R10 irq", DW'(irq), 0);
    chk("R10 rdata", rdata, 0);
    rdr('h34); chk("R10 raw", last_rd, 0);
    rdr('h30); chk("R10 mask", last_rd, 0);
    rdr('h80); chk("R10 cause", last_rd, 0);

    // R1 each edge event sets its own bit
    exp_raw = '0;
    for (int k = 0; k < 10; k++) begin
      cyc(0, 0, 0, '0, 10'(1 << k), '0);
      exp_raw[ebit[k]] = 1'b1;
      rdr('h34); chk($sformatf("R1 set k=%0d", k), last_rd, DW'(exp_raw));
    end
    chk("R1 all edges", DW'(exp_raw), 32'hFEB);

    // R5 individual clears, one at a time; others untouched
    for (int k = 0; k < 10; k++) begin
      rdr('h44 + 4 * k); chk($sformatf("R5 preclear k=%0d", k), last_rd, 1);
      exp_raw[ebit[k]] = 1'b0;
      rdr('h34); chk($sformatf("R5 remain k=%0d", k), last_rd, DW'(exp_raw));
      rdr('h44 + 4 * k); chk($sformatf("R5 again k=%0d", k), last_rd, 0);
    end

    // R2 level sources follow inputs, unaffected by clears
    rxl = 1; @(negedge clk);
    rdr('h34); chk("R2 rx level", last_rd, 32'h004);
    txl = 1; @(negedge clk);
    rdr('h40); chk("R2 clr_all no edge", last_rd, 0);
    rdr('h34); chk("R2 after clr_all", last_rd, 32'h014);
    for (int k = 0; k < 10; k++) rdr('h44 + 4 * k);
    rdr('h34); chk("R2 after all clears", last_rd, 32'h014);
    rxl = 0; txl = 0; @(negedge clk);
    rdr('h34); chk("R2 level low", last_rd, 0);

    // R3 / R4 mask sweep over single bits plus 0 and all ones
    cyc(0, 0, 0, '0, 10'h2A5, '0);  // edges 0,2,5,7,9 -> bits 0,3,7,9,11
    exp_raw = 12'hA89;
    for (int m = 0; m < 14; m++) begin
      logic [11:0] mk;
      mk = (m < 12) ? 12'(1 << m) : ((m == 12) ? 12'h000 : 12'hFFF);
      wrr('h30, DW'(mk) | 32'hFFFF_0000);
      @(negedge clk);
      chk($sformatf("R4 irq m=0x%0h", mk), DW'(irq), DW'(|(exp_raw & mk)));
      rdr('h30); chk($sformatf("R3 mask m=0x%0h", mk), last_rd, DW'(mk));
      rdr('h2C); chk($sformatf("R3 mstat m=0x%0h", mk), last_rd, DW'(exp_raw & mk));
    end
    // R4 latency: clearing the only masked flag drops irq one cycle later
    wrr('h30, 32'h800); @(negedge clk);
    chk("R4 irq high", DW'(irq), 1);
    rdr('h68);
    chk("R4 irq lags clear", DW'(irq), 1);
    @(negedge clk);
    chk("R4 irq low", DW'(irq), 0);
    exp_raw[11] = 0;

    // R6 combined clear
    rdr('h40); chk("R6 clr_all ret", last_rd, 1);
    rdr('h34); chk("R6 raw empty", last_rd, 0);
    rdr('h40); chk("R6 clr_all ret empty", last_rd, 0);

    // R7 event coinciding with clear
    cyc(0, 0, 0, '0, 10'h008, '0);
    cyc(1, 0, 'h44 + 4 * 3, '0, 10'h008, '0);
    chk("R7 preclear", last_rd, 1);
    rdr('h34); chk("R7 kept set", last_rd, 32'h020);
    cyc(1, 0, 'h40, '0, 10'h3FF, '0);
    chk("R7 clr_all ret", last_rd, 1);
    rdr('h34); chk("R7 all kept", last_rd, 32'hFEB);
    rdr('h40); rdr('h34); chk("R7 then cleared", last_rd, 0);

    // R8 abort cause accumulation and clear
    cyc(0, 0, 0, '0, 10'h010, 16'h0009);
    rdr('h80); chk("R8 cause first", last_rd, 32'h0009);
    cyc(0, 0, 0, '0, 10'h010, 16'h0100);
    rdr('h80); chk("R8 cause or", last_rd, 32'h0109);
    cyc(0, 0, 0, '0, 10'h001, 16'h4000);
    rdr('h80); chk("R8 no load w/o abort", last_rd, 32'h0109);
    rdr('h80); chk("R9 cause read hold", last_rd, 32'h0109);
    rdr('h54); chk("R8 abort flag ret", last_rd, 1);
    rdr('h80); chk("R8 cause cleared", last_rd, 0);
    cyc(1, 0, 'h54, '0, 10'h010, 16'h0020);
    rdr('h80); chk("R8 cause collision kept", last_rd, 32'h0020);
    rdr('h40);
    rdr('h80); chk("R8 cause clr_all", last_rd, 0);

    // R9 unmapped reads, idle data, stray writes
    cyc(0, 0, 0, '0, 10'h060, '0);  // bits 7,8
    rdr('h00); chk("R9 unmapped 00", last_rd, 0);
    rdr('h3C); chk("R9 unmapped 3C", last_rd, 0);
    rdr('h6C); chk("R9 unmapped 6C", last_rd, 0);
    @(negedge clk); chk("R9 idle rdata", rdata, 0);
    wrr('h34, 32'h0); wrr('h2C, 32'h0); wrr('h44 + 4 * 5, 32'h0);
    rdr('h34); chk("R9 stray writes", last_rd, 32'h180);
    rdr('h30); chk("R9 mask kept", last_rd, 32'h800);

    // R10 reset mid-operation
    wrr('h30, 32'hFFF);
    cyc(0, 0, 0, '0, 10'h010, 16'h00FF);
    @(negedge clk);
    chk("R10 pre irq", DW'(irq), 1);
    rst = 1; @(negedge clk); rst = 0;
    chk("R10 irq cleared", DW'(irq), 0);
    rdr('h34); chk("R10 raw cleared", last_rd, 0);
    rdr('h30); chk("R10 mask cleared", last_rd, 0);
    rdr('h80); chk("R10 cause cleared", last_rd, 0);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule